// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the byte address of a load or store and the value that the base register should take once the access is done. It takes a base value, an offset drawn either from a 12-bit unsigned constant or from a second register shifted left by a chosen amount, an add/subtract selector, an access size and an indexing mode. It produces the access address, the updated base value with an enable that marks a real base update, and a flag for an access whose address does not suit its size.

Four indexing modes are supported. Plain offset uses base±offset and leaves the base alone. Pre-indexed with update uses base±offset and also writes that sum back. Post-indexed uses the untouched base for the access and writes base±offset back. Register-indirect uses the base alone and ignores every offset input. All outputs are registered, so the result of an input set appears one clock after the rising edge that samples it. The register file, the memory port and any data lane steering or sign extension live in neighbouring blocks.

Top module: `agu_lsu_addr`

## Requirements
- R1: While rst_n is low, addr_o, wb_val_o, wb_en_o and misalign_o are all zero, whatever the other inputs are.
- R2: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency), and a new input set may be applied every cycle.
- R3: With use_reg_i = 0 the offset is imm_i zero-extended to 32 bits. With use_reg_i = 1 the offset is idx_reg_i shifted left by shamt_i (0 to 31), and bits shifted past bit 31 are lost.
- R4: With sub_i = 1 the offset is subtracted from the base, otherwise it is added; the result wraps modulo 2^32.
- R5: mode_i = 0 (offset): addr_o is base±offset, wb_en_o is 0 and wb_val_o equals the base.
- R6: mode_i = 1 (pre-indexed with update): addr_o is base±offset, wb_en_o is 1 and wb_val_o equals addr_o.
- R7: mode_i = 2 (post-indexed): addr_o equals the base, wb_en_o is 1 and wb_val_o is base±offset.
- R8: mode_i = 3 (register-indirect): addr_o and wb_val_o both equal the base and wb_en_o is 0; imm_i, idx_reg_i, use_reg_i, shamt_i and sub_i have no effect.
- R9: With size_i = 2 (word), misalign_o is 1 exactly when addr_o[1:0] is not 00.
- R10: With size_i = 1 (halfword), misalign_o is 1 exactly when addr_o[0] is 1; with size_i = 0 (byte) or the unused code 3, misalign_o is always 0.
- R11: misalign_o is judged on the access address, so in post-indexed mode an unaligned updated base does not raise it when the base itself is aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Unsigned constant offset |
| idx_reg_i | input | 32 | Index register value |
| use_reg_i | input | 1 | 1 selects the shifted index register as offset |
| shamt_i | input | 5 | Left shift applied to the index register |
| sub_i | input | 1 | 1 subtracts the offset, 0 adds it |
| mode_i | input | 2 | Indexing mode: 0 offset, 1 pre-indexed update, 2 post-indexed, 3 indirect |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 unused |
| addr_o | output | 32 | Access byte address |
| wb_val_o | output | 32 | Updated base value |
| wb_en_o | output | 1 | Base update required |
| misalign_o | output | 1 | Address not aligned to access size |

## Verification
The bench targets the places where a plausible slip changes only one output: post-indexed mode swapping address and update value would hand memory the summed address, and a misalign check run on the sum instead of the access address would flag aligned post-indexed accesses. Subtraction across zero and shifts that push index bits past bit 31 catch an adder or shifter of the wrong width, which would leave stray upper bits. Indirect mode is driven with busy offset inputs so a decoder that leaks the offset produces a shifted address, and halfword/word/byte sizes are paired with odd and even addresses so a swapped size decode misreports alignment.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        MODE_OFFSET   = 2'd0,
        MODE_PRE_WB   = 2'd1,
        MODE_POST     = 2'd2,
        MODE_INDIRECT = 2'd3
    } agu_mode_e;

    typedef enum logic [1:0] {
        SIZE_BYTE = 2'd0,
        SIZE_HALF = 2'd1,
        SIZE_WORD = 2'd2,
        SIZE_RSVD = 2'd3
    } agu_size_e;

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12,
    parameter int SH_W   = 5
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] idx_reg_i,
    input  logic              use_reg_i,
    input  logic [SH_W-1:0]   shamt_i,
    output logic [ADDR_W-1:0] offset_o
);
    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] reg_scaled;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_ext = {{PAD_W{1'b0}}, imm_i};
        end else begin : g_nopad
            assign imm_ext = imm_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        reg_scaled = idx_reg_i << shamt_i;
        offset_o   = use_reg_i ? reg_scaled : imm_ext;
    end

endmodule

// File: rtl/agu_base_adder.sv
module agu_base_adder #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic              sub_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] operand;

    always_comb begin
        // two's complement subtract: base + ~off + 1
        operand = sub_i ? ~offset_i : offset_i;
        sum_o   = base_i + operand + {{(ADDR_W-1){1'b0}}, sub_i};
    end

endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk
    import agu_pkg::*;
(
    input  logic [1:0] addr_lo_i,
    input  agu_size_e  size_i,
    output logic       misalign_o
);
    always_comb begin
        unique case (size_i)
            SIZE_WORD: misalign_o = |addr_lo_i;
            SIZE_HALF: misalign_o = addr_lo_i[0];
            default:   misalign_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/agu_lsu_addr.sv
module agu_lsu_addr
    import agu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12,
    parameter int SH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [ADDR_W-1:0] idx_reg_i,
    input  logic              use_reg_i,
    input  logic [SH_W-1:0]   shamt_i,
    input  logic              sub_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] wb_val_o,
    output logic              wb_en_o,
    output logic              misalign_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] wb_val;
        logic              wb_en;
        logic              misalign;
    } agu_out_t;

    agu_mode_e mode;
    agu_size_e size;

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] acc_addr;
    logic [ADDR_W-1:0] upd_val;
    logic              upd_en;
    logic              mis;

    agu_out_t out_d;
    agu_out_t out_q;

    assign mode = agu_mode_e'(mode_i);
    assign size = agu_size_e'(size_i);

    agu_offset_sel #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W),
        .SH_W   (SH_W)
    ) u_off (
        .imm_i     (imm_i),
        .idx_reg_i (idx_reg_i),
        .use_reg_i (use_reg_i),
        .shamt_i   (shamt_i),
        .offset_o  (offset)
    );

    agu_base_adder #(
        .ADDR_W (ADDR_W)
    ) u_add (
        .base_i   (base_i),
        .offset_i (offset),
        .sub_i    (sub_i),
        .sum_o    (sum)
    );

    // mode decode: which value goes to memory, which to the base register
    always_comb begin
        unique case (mode)
            MODE_OFFSET: begin
                acc_addr = sum;
                upd_val  = base_i;
                upd_en   = 1'b0;
            end
            MODE_PRE_WB: begin
                acc_addr = sum;
                upd_val  = sum;
                upd_en   = 1'b1;
            end
            MODE_POST: begin
                acc_addr = base_i;
                upd_val  = sum;
                upd_en   = 1'b1;
            end
            default: begin
                acc_addr = base_i;
                upd_val  = base_i;
                upd_en   = 1'b0;
            end
        endcase
    end

    agu_align_chk u_align (
        .addr_lo_i  (acc_addr[1:0]),
        .size_i     (size),
        .misalign_o (mis)
    );

    always_comb begin
        out_d          = out_q;
        out_d.addr     = acc_addr;
        out_d.wb_val   = upd_val;
        out_d.wb_en    = upd_en;
        out_d.misalign = mis;
        if (!rst_n) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign addr_o     = out_q.addr;
    assign wb_val_o   = out_q.wb_val;
    assign wb_en_o    = out_q.wb_en;
    assign misalign_o = out_q.misalign;

    // ---------------- assertions ----------------
    assert_offset_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == MODE_OFFSET)
        |-> (!wb_en_o && wb_val_o == $past(base_i)));

    assert_pre_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == MODE_PRE_WB)
        |-> (wb_en_o && wb_val_o == addr_o));

    assert_post_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == MODE_POST)
        |-> (wb_en_o && addr_o == $past(base_i)));

    assert_indirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i) == MODE_INDIRECT)
        |-> (!wb_en_o && addr_o == $past(base_i) && wb_val_o == $past(base_i)));

    assert_word_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(size_i) == SIZE_WORD)
        |-> (misalign_o == (addr_o[1:0] != 2'b00)));

    assert_narrow_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> ($past(size_i) == SIZE_WORD || $past(size_i) == SIZE_HALF));

endmodule

// File: tb/agu_lsu_addr_tb.sv
module agu_lsu_addr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = '0;
    logic [11:0] imm_i = '0;
    logic [31:0] idx_reg_i = '0;
    logic        use_reg_i = 1'b0;
    logic [4:0]  shamt_i = '0;
    logic        sub_i = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] addr_o;
    logic [31:0] wb_val_o;
    logic        wb_en_o;
    logic        misalign_o;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;
    string tag_in = "R2";
    string tag_q  = "R1";

    logic [31:0] e_addr = '0;
    logic [31:0] e_wbv  = '0;
    logic        e_wb   = 1'b0;
    logic        e_mis  = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    agu_lsu_addr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_i     (base_i),
        .imm_i      (imm_i),
        .idx_reg_i  (idx_reg_i),
        .use_reg_i  (use_reg_i),
        .shamt_i    (shamt_i),
        .sub_i      (sub_i),
        .mode_i     (mode_i),
        .size_i     (size_i),
        .addr_o     (addr_o),
        .wb_val_o   (wb_val_o),
        .wb_en_o    (wb_en_o),
        .misalign_o (misalign_o)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        longint unsigned off;
        longint unsigned s;
        logic [31:0] sum32;
        logic [31:0] acc;
        if (!rst_n) begin
            e_addr = '0; e_wbv = '0; e_wb = 1'b0; e_mis = 1'b0;
            tag_q  = "R1";
        end else begin
            if (use_reg_i) off = (longint'(idx_reg_i) * (64'd1 << shamt_i)) % 64'h1_0000_0000;
            else           off = longint'(imm_i);
            if (sub_i) s = (64'h1_0000_0000 + longint'(base_i) - off) % 64'h1_0000_0000;
            else       s = (longint'(base_i) + off) % 64'h1_0000_0000;
            sum32 = s[31:0];
            case (mode_i)
                2'd0:    begin acc = sum32;  e_wbv = base_i; e_wb = 1'b0; end
                2'd1:    begin acc = sum32;  e_wbv = sum32;  e_wb = 1'b1; end
                2'd2:    begin acc = base_i; e_wbv = sum32;  e_wb = 1'b1; end
                default: begin acc = base_i; e_wbv = base_i; e_wb = 1'b0; end
            endcase
            e_addr = acc;
            if (size_i == 2'd2)      e_mis = (acc % 4) != 0;
            else if (size_i == 2'd1) e_mis = (acc % 2) != 0;
            else                     e_mis = 1'b0;
            tag_q = tag_in;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk(tag_q, "addr_o", addr_o, e_addr);
            chk(tag_q, "wb_val_o", wb_val_o, e_wbv);
            chk(tag_q, "wb_en_o", {31'd0, wb_en_o}, {31'd0, e_wb});
            chk(tag_q, "misalign_o", {31'd0, misalign_o}, {31'd0, e_mis});
        end
    end

    task automatic put(input logic [31:0] b, input logic [11:0] im, input logic [31:0] rg,
                       input logic ur, input logic [4:0] sh, input logic sb,
                       input logic [1:0] md, input logic [1:0] sz, input string tag);
        @(negedge clk);
        base_i = b; imm_i = im; idx_reg_i = rg; use_reg_i = ur;
        shamt_i = sh; sub_i = sb; mode_i = md; size_i = sz; tag_in = tag;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: busy inputs while held in reset
        base_i = 32'h1234_5679; imm_i = 12'hABC; mode_i = 2'd1; size_i = 2'd2;
        repeat (3) @(negedge clk);
        chk("R1", "addr_o reset", addr_o, 32'h0);
        chk("R1", "wb_val_o reset", wb_val_o, 32'h0);
        chk("R1", "wb_en_o reset", {31'd0, wb_en_o}, 32'h0);
        chk("R1", "misalign_o reset", {31'd0, misalign_o}, 32'h0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        put(32'h0000_1000, 12'h010, 32'h0,         1'b0, 5'd0, 1'b0, 2'd0, 2'd2, "R5");
        put(32'h0000_2000, 12'h000, 32'h8,         1'b1, 5'd0, 1'b1, 2'd0, 2'd2, "R4");
        put(32'h0000_0100, 12'h000, 32'h3,         1'b1, 5'd2, 1'b0, 2'd0, 2'd2, "R3");
        put(32'h0000_0000, 12'hFFF, 32'hFFFF_FFFF, 1'b0, 5'd0, 1'b0, 2'd0, 2'd2, "R9");
        put(32'h8000_0000, 12'h000, 32'h8000_0001, 1'b1, 5'd1, 1'b0, 2'd0, 2'd1, "R3");
        put(32'h0000_0010, 12'h020, 32'h0,         1'b0, 5'd0, 1'b1, 2'd0, 2'd0, "R4");
        put(32'h0000_0400, 12'h004, 32'h0,         1'b0, 5'd0, 1'b0, 2'd1, 2'd2, "R6");
        put(32'h0000_0400, 12'h010, 32'h0,         1'b0, 5'd0, 1'b1, 2'd1, 2'd1, "R6");
        put(32'h0000_0400, 12'h010, 32'h0,         1'b0, 5'd0, 1'b0, 2'd2, 2'd2, "R7");
        put(32'h0000_0400, 12'h001, 32'h0,         1'b0, 5'd0, 1'b0, 2'd2, 2'd1, "R11");
        put(32'h0000_0400, 12'h000, 32'h7,         1'b1, 5'd4, 1'b1, 2'd2, 2'd2, "R7");
        put(32'h0000_0503, 12'hFFF, 32'hDEAD_BEEF, 1'b1, 5'd7, 1'b1, 2'd3, 2'd1, "R8");
        put(32'h0000_0502, 12'h001, 32'h0,         1'b0, 5'd0, 1'b0, 2'd3, 2'd2, "R8");
        put(32'h0000_0006, 12'h000, 32'h0,         1'b0, 5'd0, 1'b0, 2'd0, 2'd2, "R9");
        put(32'h0000_0007, 12'h000, 32'h0,         1'b0, 5'd0, 1'b0, 2'd0, 2'd0, "R10");
        put(32'h0000_0007, 12'h000, 32'h0,         1'b0, 5'd0, 1'b0, 2'd0, 2'd3, "R10");
        put(32'h0000_0006, 12'h000, 32'h0,         1'b0, 5'd0, 1'b0, 2'd0, 2'd1, "R10");

        // R2: a fresh random input set every cycle
        for (int i = 0; i < 600; i++) begin
            put($urandom, 12'($urandom), $urandom, 1'($urandom), 5'($urandom),
                1'($urandom), 2'($urandom), 2'($urandom), "R2");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule